// File: doc/BRIEF.md
# Byte write controller with completion detection

This block sits on the host side of a parallel memory whose byte writes run on an internal timer. Each request carries an address, a data byte and a mode bit. The block drives a single write strobe onto the memory bus. It then waits for the memory's own write cycle to finish before it accepts another request.

Two completion checks are available, and the mode bit of each request selects one:

- **Read-back polling.** The block reads the same address again and again. It finishes when the polled data bit returns to the value that was written. While the write is still running, the memory returns that bit inverted.
- **Busy-line sensing.** The block watches a shared, active-low, open-drain busy line through a synchroniser. It finishes once the line is high. Any device on the line holding it low keeps the block waiting.

One timeout counter guards both modes. When the memory finishes, the block gives a one-cycle done pulse. When the timeout runs out first, it gives a one-cycle error pulse instead.

Top module: `eewr_host_ctrl`

## Requirements
- R1: Each write asserts chip enable (low) with output enable held high, then drives write enable low for exactly WE_CYC consecutive cycles. Write enable is never low unless chip enable is low and output enable is high.
- R2: While write enable is low, address and write data stay constant. The data bus driver enable (`mem_dq_oe` = 1) is only ever on while output enable is high. Each accepted byte lands at its requested address.
- R3: A polling read holds chip enable and output enable low, with write enable high and the data driver off, for exactly ACC_CYC cycles. The polled bit is data bit 7 (POLL_BIT = DATA_W-1). An idle turnaround cycle with all strobes high separates consecutive reads.
- R4: In polling mode (`req_mode` = 0), done is reported only after a read whose bit 7 equals bit 7 of the written byte. This holds for both values of that bit, and done never comes before the memory has finished its write.
- R5: In busy-line mode (`req_mode` = 1), done is reported only once the synchronised busy line reads high. A low driven by any other device on the wired-OR line keeps the controller waiting.
- R6: `req_ready` is high only in idle, with all strobes inactive. It falls in the cycle after a request is accepted. No new access starts before the previous write's completion is seen, and a request held during that time has no effect on memory.
- R7: If completion is not seen within TIMEOUT_CYC cycles of waiting, `timeout_err` pulses and done does not. The pulse becomes visible exactly 2 + WE_CYC + TIMEOUT_CYC clock edges after the accepting edge. The controller then returns to idle.
- R8: During reset all strobes are high, the data driver is off, `req_ready` is high and both `done` and `timeout_err` are low.
- R9: `done` and `timeout_err` are single-cycle pulses and are never high together.
- R10: In busy-line mode, the busy line is ignored for BLANK_CYC cycles after the write strobe ends. This stops a line that has not yet dropped from being taken as completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_mode | input | 1 | Completion check: 0 read-back polling, 1 busy line |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| done | output | 1 | One-cycle pulse: write completion detected |
| timeout_err | output | 1 | One-cycle pulse: completion not seen in time |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | DATA_W | Data read from the memory |
| mem_busy_n | input | 1 | Shared wired-OR busy line, low while any device is busy |

## Verification
The bench goes after these corner cases:

- **Busy line slow to fall.** The memory model lowers the busy line two cycles after the write strobe ends. A controller without the blanking window would see the stale high level and report done long before the memory finished.
- **Polled bit value.** Polling runs with bit 7 both set and clear. A controller that compares the wrong value or the wrong polarity would either stop at once or run into the timeout.
- **Another device holding the line.** A second device holds the shared line low well past the memory's own completion. A controller that tracked only its own device would finish early.
- **Timeouts in both modes.** The error pulse is checked at its exact edge. A controller with an off-by-one counter would miss that edge.
- **Request held during a write.** A second request is held on the port while a write is running. A controller that accepted it early would change memory before the first write was detected as complete.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WPULSE,
      ST_HOLD,
      ST_GAP,
      ST_READ,
      ST_BLANK,
      ST_BWAIT
   } wr_state_e;

   typedef enum logic {
      CHK_POLL = 1'b0,
      CHK_BUSY = 1'b1
   } chk_mode_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/eewr_sync.sv
module eewr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eewr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
            else        sh_q <= {sh_q[0], d};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
            else        sh_q <= {sh_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/eewr_tmo.sv
module eewr_tmo #(
   parameter int LIMIT = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic expired
);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("eewr_tmo: LIMIT must be at least 2");
      end
   endgenerate

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expired = active && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (active && !expired) cnt_q <= cnt_q + 1'b1;
      else                        cnt_q <= '0;
   end

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0));

endmodule

// File: rtl/eewr_pollcmp.sv
module eewr_pollcmp #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = DATA_W - 1
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] wr_data,
   output logic              match
);

   generate
      if (POLL_BIT >= DATA_W || POLL_BIT < 0) begin : g_bad_bit
         $error("eewr_pollcmp: POLL_BIT outside the data word");
      end
   endgenerate

   assign match = ~(rd_data[POLL_BIT] ^ wr_data[POLL_BIT]);

endmodule

// File: rtl/eewr_host_ctrl.sv
module eewr_host_ctrl
   import eewr_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int POLL_BIT    = DATA_W - 1,
   parameter int WE_CYC      = 3,
   parameter int ACC_CYC     = 2,
   parameter int BLANK_CYC   = 8,
   parameter int TIMEOUT_CYC = 4000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_mode,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_ready,
   output logic              done,
   output logic              timeout_err,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   input  logic              mem_busy_n
);

   generate
      if (ACC_CYC < 2) begin : g_bad_acc
         $error("eewr_host_ctrl: ACC_CYC must be at least 2");
      end
      if (WE_CYC < 1) begin : g_bad_we
         $error("eewr_host_ctrl: WE_CYC must be at least 1");
      end
      if (BLANK_CYC < SYNC_STAGES + 2) begin : g_bad_blank
         $error("eewr_host_ctrl: BLANK_CYC must cover the synchroniser delay");
      end
   endgenerate

   localparam int PH_MAX = max3(WE_CYC, ACC_CYC, BLANK_CYC);
   localparam int PH_W   = $clog2(PH_MAX + 1);
   localparam logic [PH_W-1:0] WE_LAST    = PH_W'(WE_CYC - 1);
   localparam logic [PH_W-1:0] ACC_LAST   = PH_W'(ACC_CYC - 1);
   localparam logic [PH_W-1:0] BLANK_LAST = PH_W'(BLANK_CYC - 1);

   wr_state_e         state_q, state_d;
   logic [PH_W-1:0]   ph_q, ph_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   chk_mode_e         mode_q;
   logic              done_q, err_q;

   logic line_free;
   logic poll_hit;
   logic wait_st;
   logic tmo_hit;
   logic finish;

   eewr_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) i_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mem_busy_n),
      .q     (line_free)
   );

   eewr_pollcmp #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT)
   ) i_pollcmp (
      .rd_data (mem_dq_in),
      .wr_data (data_q),
      .match   (poll_hit)
   );

   assign wait_st = (state_q == ST_GAP)   || (state_q == ST_READ) ||
                    (state_q == ST_BLANK) || (state_q == ST_BWAIT);

   eewr_tmo #(
      .LIMIT (TIMEOUT_CYC)
   ) i_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (wait_st),
      .expired (tmo_hit)
   );

   assign finish = ((state_q == ST_READ) && (ph_q == ACC_LAST) && poll_hit) ||
                   ((state_q == ST_BWAIT) && line_free);

   always_comb begin
      state_d = state_q;
      ph_d    = '0;
      unique case (state_q)
         ST_IDLE:   if (req_valid) state_d = ST_SETUP;
         ST_SETUP:  state_d = ST_WPULSE;
         ST_WPULSE: begin
            if (ph_q == WE_LAST) state_d = ST_HOLD;
            else                 ph_d    = ph_q + 1'b1;
         end
         ST_HOLD:   state_d = (mode_q == CHK_BUSY) ? ST_BLANK : ST_GAP;
         ST_GAP:    state_d = ST_READ;
         ST_READ: begin
            if (ph_q == ACC_LAST) state_d = poll_hit ? ST_IDLE : ST_GAP;
            else                  ph_d    = ph_q + 1'b1;
         end
         ST_BLANK: begin
            if (ph_q == BLANK_LAST) state_d = ST_BWAIT;
            else                    ph_d    = ph_q + 1'b1;
         end
         ST_BWAIT:  if (line_free) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
      if (tmo_hit && !finish) begin
         state_d = ST_IDLE;
         ph_d    = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ph_q    <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         mode_q  <= CHK_POLL;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ph_q    <= ph_d;
         done_q  <= finish;
         err_q   <= tmo_hit && !finish;
         if (state_q == ST_IDLE && req_valid) begin
            addr_q <= req_addr;
            data_q <= req_data;
            mode_q <= chk_mode_e'(req_mode);
         end
      end
   end

   always_comb begin
      mem_ce_n  = 1'b1;
      mem_oe_n  = 1'b1;
      mem_we_n  = 1'b1;
      mem_dq_oe = 1'b0;
      unique case (state_q)
         ST_SETUP, ST_HOLD: begin
            mem_ce_n  = 1'b0;
            mem_dq_oe = 1'b1;
         end
         ST_WPULSE: begin
            mem_ce_n  = 1'b0;
            mem_we_n  = 1'b0;
            mem_dq_oe = 1'b1;
         end
         ST_READ: begin
            mem_ce_n = 1'b0;
            mem_oe_n = 1'b0;
         end
         default: ;
      endcase
   end

   assign mem_addr    = addr_q;
   assign mem_dq_out  = data_q;
   assign req_ready   = (state_q == ST_IDLE);
   assign done        = done_q;
   assign timeout_err = err_q;

   // Checker-side run-length counters for strobe widths
   logic [7:0] we_lo_cnt, oe_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         oe_lo_cnt <= '0;
      end else begin
         we_lo_cnt <= mem_we_n ? 8'd0 : we_lo_cnt + 8'd1;
         oe_lo_cnt <= mem_oe_n ? 8'd0 : oe_lo_cnt + 8'd1;
      end
   end

   assert_strobe_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n));

   assert_we_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt == 8'(WE_CYC)));

   assert_no_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_stable_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   assert_read_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

   assert_read_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_lo_cnt == 8'(ACC_CYC)));

   assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> $past(wait_st));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> !timeout_err);

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout_err));

endmodule

// File: tb/test_eewr_host_ctrl.sv
module test_eewr_host_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 11;
   localparam int DW  = 8;
   localparam int WE  = 3;
   localparam int ACC = 2;
   localparam int BLK = 8;
   localparam int TO  = 300;
   localparam int BUSY_LAT = 2;
   localparam int TO_EDGES = 2 + WE + TO;

   typedef struct packed {
      logic        mode;
      logic [10:0] addr;
      logic [7:0]  data;
      logic [15:0] wt;
      logic [15:0] hold;
      logic        to;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 11'h123, 8'hA5, 16'd40,   16'd0,    1'b0},
      '{1'b0, 11'h7FF, 8'h3C, 16'd25,   16'd0,    1'b0},
      '{1'b1, 11'h000, 8'hFF, 16'd50,   16'd0,    1'b0},
      '{1'b1, 11'h400, 8'h5A, 16'd30,   16'd120,  1'b0},
      '{1'b0, 11'h055, 8'h81, 16'd1000, 16'd0,    1'b1},
      '{1'b1, 11'h2AA, 8'h7E, 16'd40,   16'd2000, 1'b1},
      '{1'b0, 11'h001, 8'h00, 16'd5,    16'd0,    1'b0},
      '{1'b1, 11'h3FF, 8'h80, 16'd12,   16'd0,    1'b0}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid, req_mode;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic req_ready, done, timeout_err;
   logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out, mem_dq_in;
   logic mem_busy_n;
   logic other_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int viol = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eewr_host_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .WE_CYC(WE), .ACC_CYC(ACC),
      .BLANK_CYC(BLK), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)
   ) i_eewr_host_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_mode(req_mode),
      .req_addr(req_addr), .req_data(req_data),
      .req_ready(req_ready), .done(done), .timeout_err(timeout_err),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_busy_n(mem_busy_n)
   );

   // Behavioural self-timed memory
   logic [7:0] mem [0:2047];
   logic prev_we = 1'b1;
   logic [10:0] lat_addr = '0;
   logic [7:0] lat_data = '0;
   logic dev_busy = 1'b0;
   logic busy_vis = 1'b0;
   int remain = 0;
   int lat_cnt = 0;
   int dev_wtime = 10;

   always @(posedge clk) begin
      prev_we <= mem_we_n;
      if (!mem_ce_n && !mem_we_n && prev_we) lat_addr <= mem_addr;
      if (mem_we_n && !prev_we) begin
         lat_data <= mem_dq_out;
         dev_busy <= 1'b1;
         busy_vis <= 1'b0;
         remain   <= dev_wtime;
         lat_cnt  <= BUSY_LAT;
      end else if (dev_busy) begin
         if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
         else             busy_vis <= 1'b1;
         if (remain <= 1) begin
            mem[lat_addr] <= lat_data;
            dev_busy <= 1'b0;
            busy_vis <= 1'b0;
         end else begin
            remain <= remain - 1;
         end
      end
   end

   assign mem_busy_n = ~busy_vis & other_n;
   assign mem_dq_in  = (!mem_ce_n && !mem_oe_n) ?
                       (dev_busy ? {~lat_data[7], ~lat_data[6:0]} : mem[mem_addr]) : 8'h00;

   // Monitor: no write strobe or bus drive while the memory is still busy (R6)
   always @(negedge clk) begin
      if (rst_n && dev_busy && (!mem_we_n || mem_dq_oe)) viol++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Watchdog: counts as a failed check and still prints the summary
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run(input logic md, input logic [10:0] a, input logic [7:0] d,
                      input int wt, input int hold,
                      output int n, output bit gd, output bit ge);
      bit rdy_low;
      rdy_low = 1'b1;
      dev_wtime = wt;
      if (hold > 0) other_n = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_mode = md; req_addr = a; req_data = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!(done || timeout_err) && n < 6000) begin
         if (req_ready) rdy_low = 1'b0;
         if (n == hold) other_n = 1'b1;
         @(negedge clk);
         n++;
      end
      gd = done;
      ge = timeout_err;
      chk(rdy_low, "R6", "ready stayed low while waiting", int'(rdy_low), 1);
      @(negedge clk);
      chk(!done && !timeout_err, "R9", "outcome pulse lasts one cycle",
          int'({done, timeout_err}), 0);
      other_n = 1'b1;
      while (dev_busy) @(negedge clk);
   endtask

   initial begin
      int n;
      bit gd, ge;
      rst_n = 1'b0; req_valid = 1'b0; req_mode = 1'b0;
      req_addr = '0; req_data = '0; other_n = 1'b1;
      for (int k = 0; k < 2048; k++) mem[k] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R8", "strobes idle in reset",
          int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
      chk(!mem_dq_oe, "R8", "driver off in reset", int'(mem_dq_oe), 0);
      chk(req_ready, "R8", "ready in reset", int'(req_ready), 1);
      chk(!done && !timeout_err, "R8", "no pulses in reset",
          int'({done, timeout_err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Vector table: mode, address, data, device time, other-device hold, timeout
      for (int i = 0; i < 8; i++) begin
         run(VECS[i].mode, VECS[i].addr, VECS[i].data,
             int'(VECS[i].wt), int'(VECS[i].hold), n, gd, ge);
         if (VECS[i].to) begin
            chk(ge && !gd, "R7", $sformatf("vec %0d timeout reported", i),
                int'({gd, ge}), 1);
            chk(n == TO_EDGES, "R7", $sformatf("vec %0d timeout edge", i), n, TO_EDGES);
         end else begin
            chk(gd && !ge, VECS[i].mode ? "R5" : "R4",
                $sformatf("vec %0d done reported", i), int'({gd, ge}), 2);
            chk(n >= int'(VECS[i].wt), VECS[i].mode ? "R10" : "R4",
                $sformatf("vec %0d not before memory finished", i),
                n, int'(VECS[i].wt));
            chk(n <= int'(VECS[i].wt) + int'(VECS[i].hold) + 30, "R3",
                $sformatf("vec %0d completion latency bound", i),
                n, int'(VECS[i].wt) + int'(VECS[i].hold) + 30);
            if (VECS[i].hold > 0)
               chk(n > int'(VECS[i].hold), "R5",
                   $sformatf("vec %0d waits for other device", i),
                   n, int'(VECS[i].hold) + 1);
         end
         chk(mem[VECS[i].addr] == VECS[i].data, "R2",
             $sformatf("vec %0d byte stored", i),
             int'(mem[VECS[i].addr]), int'(VECS[i].data));
      end

      // Directed: second request held on the port during a running write (R6)
      begin
         bit untouched;
         int guard;
         untouched = 1'b1;
         guard = 0;
         dev_wtime = 60;
         @(negedge clk);
         req_valid = 1'b1; req_mode = 1'b1; req_addr = 11'h111; req_data = 8'hC3;
         @(posedge clk);
         @(negedge clk);
         req_addr = 11'h222; req_data = 8'h4B;
         while (!done && guard < 2000) begin
            if (mem[11'h222] != 8'h00) untouched = 1'b0;
            @(negedge clk);
            guard++;
         end
         chk(untouched, "R6", "held request left memory unchanged",
             int'(mem[11'h222]), 0);
         chk(mem[11'h111] == 8'hC3, "R1", "first byte stored",
             int'(mem[11'h111]), 8'hC3);
         @(negedge clk);
         req_valid = 1'b0;
         guard = 0;
         while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
         chk(done, "R5", "second request completed", int'(done), 1);
         while (dev_busy) @(negedge clk);
         chk(mem[11'h222] == 8'h4B, "R2", "second byte stored",
             int'(mem[11'h222]), 8'h4B);
      end

      chk(viol == 0, "R6", "no access while memory busy", viol, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule